// File: doc/BRIEF.md
# Byte-Serial SPN Block Encryptor

This block encrypts one 64-bit block under a 64-bit key, handling a single byte per clock. Each round XORs in a subkey, substitutes both nibbles of every byte through a fixed 4-bit S-box, rotates the block left by two byte positions, and mixes each 32-bit half with the AES column coefficients. The subkey for the next round is derived while the current round streams through, so no separate key expansion pass is needed.

A host raises `start` for one cycle while the block is idle, presenting byte 0 of the plaintext and key in that same cycle, then bytes 1 to 7 on the seven following cycles. The first round runs while those bytes arrive. After the last round, a final subkey XOR is applied as the ciphertext bytes leave, one per cycle, with `done` marking the last of them. A new block may be started in the cycle that `done` is high.

Top module: `bsc_encrypt`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `ct_valid` and `done` are 0 and `ct_out` is 8'h00.
- R2: `start` is accepted only while `busy` is 0. Byte j (j = 0..7, byte 0 being bits 63:56 of the 64-bit value) of the plaintext and key is sampled from `txt_in`/`key_in` at the j-th clock edge counted from the edge that samples `start` (j = 0 being that edge). While idle and without `start`, `txt_in` and `key_in` have no effect on any output.
- R3: The ciphertext equals ROUNDS rounds of (XOR subkey i, nibble S-box, rotate, column mix), followed by a XOR with subkey ROUNDS+1; subkey 1 is the key.
- R4: The S-box maps nibble values 0..F to {7,4,A,9,1,F,B,0,C,3,2,6,8,E,D,5}. The rotation moves byte j+2 (mod 8) to position j. Each half (bytes 0-3 and 4-7) is mixed as out_i = 2*c_i ^ 3*c_(i+1) ^ c_(i+2) ^ c_(i+3) (indices mod 4) in GF(2^8) with polynomial 0x11B.
- R5: From subkey k0..k7 after round i, the next subkey is k5, k6, k7^i, k4, k1^k5, S(k2^k6), S(k3^k7), k0^k4, with S applied to both nibbles.
- R6: Ciphertext leaves on `ct_out` over 8 consecutive cycles with `ct_valid` high, byte 0 first; `ct_out` is 8'h00 whenever `ct_valid` is 0.
- R7: `ct_valid` first reads high after the clock edge that lies 8*ROUNDS edges after the edge that samples `start` (96 for the default).
- R8: `done` is high for exactly one cycle, in the cycle of the eighth ciphertext byte, and `busy` is 0 in that cycle.
- R9: `busy` is high for 8*(ROUNDS+1)-1 consecutive cycles after an accepted start; a `start` or changed input bytes while busy after the load have no effect on the result or the output count.
- R10: A `start` in the cycle where `done` is high begins a new block that completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; carries byte 0 in the same cycle |
| txt_in | input | 8 | Plaintext byte stream |
| key_in | input | 8 | Key byte stream |
| busy | output | 1 | Block in progress |
| ct_valid | output | 1 | `ct_out` holds a ciphertext byte |
| ct_out | output | 8 | Ciphertext byte stream |
| done | output | 1 | Last ciphertext byte of the block |

## Verification
The bench builds the block with the default round count of 12, the full schedule for a 64-bit key, so every round constant from 1 to 12 enters the key path and the full 96-cycle latency and 103-cycle busy window are measured. Several plaintext and key patterns (all zero, all ones, mixed) are compared byte by byte against a whole-block model written from the requirements, including a run that pokes `start` mid-block and a pair of runs started back to back.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int BW   = 8;   // datapath byte width
  localparam int NB   = 8;   // bytes per block
  localparam int HALF = 4;   // bytes per mixed column
  localparam int PW   = $clog2(NB);

  typedef logic [BW-1:0] byte_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_FIN} st_t;

  function automatic logic [3:0] sub4(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'h7;  4'h1: r = 4'h4;  4'h2: r = 4'hA;  4'h3: r = 4'h9;
      4'h4: r = 4'h1;  4'h5: r = 4'hF;  4'h6: r = 4'hB;  4'h7: r = 4'h0;
      4'h8: r = 4'hC;  4'h9: r = 4'h3;  4'hA: r = 4'h2;  4'hB: r = 4'h6;
      4'hC: r = 4'h8;  4'hD: r = 4'hE;  4'hE: r = 4'hD;  default: r = 4'h5;
    endcase
    return r;
  endfunction

  function automatic byte_t sub8(input byte_t b);
    return {sub4(b[7:4]), sub4(b[3:0])};
  endfunction

  function automatic byte_t dbl(input byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction
endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
#(
  parameter int ROUNDS = 12,
  localparam int RW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          ld,
  output logic          act,
  output logic          fin,
  output logic          last,
  output logic [RW-1:0] rnd,
  output logic          busy
);
  st_t           st;
  logic [PW-1:0] ph;

  assign ld   = (st == ST_IDLE && start) || st == ST_LOAD;
  assign act  = ld || st == ST_RUN;
  assign fin  = st == ST_FIN;
  assign last = ph == PW'(NB - 1);
  assign busy = st != ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      ph  <= '0;
      rnd <= RW'(1);
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_LOAD;
          ph  <= PW'(1);
          rnd <= RW'(1);
        end
        ST_LOAD, ST_RUN: begin
          ph <= ph + 1'b1;
          if (last) begin
            if (rnd == RW'(ROUNDS)) st <= ST_FIN;
            else begin
              st  <= ST_RUN;
              rnd <= rnd + 1'b1;
            end
          end
        end
        default: begin
          ph <= ph + 1'b1;
          if (last) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsc_keysched.sv
module bsc_keysched
  import bsc_pkg::*;
#(
  parameter int ROUNDS = 12,
  localparam int RW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          act,
  input  logic          fin,
  input  logic          last,
  input  logic [RW-1:0] rnd,
  input  byte_t         key_in,
  output byte_t         kb
);
  byte_t kr  [NB];
  byte_t cur [NB];
  byte_t nxt [NB];

  // kr rotates once per byte so kr[0] is always the current subkey byte
  assign kb = ld ? key_in : kr[0];

  always_comb begin
    for (int m = 0; m < NB - 1; m++) cur[m] = kr[m+1];
    cur[NB-1] = kb;
    for (int j = 0; j < HALF; j++) begin
      nxt[j]      = cur[HALF + (j+1) % HALF];
      nxt[HALF+j] = cur[(j+1) % HALF] ^ cur[HALF + (j+1) % HALF];
    end
    nxt[2] = nxt[2] ^ BW'(rnd);
    nxt[5] = sub8(nxt[5]);
    nxt[6] = sub8(nxt[6]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) kr[i] <= '0;
    end else if (act && last) begin
      for (int i = 0; i < NB; i++) kr[i] <= nxt[i];
    end else if (act || fin) begin
      for (int i = 0; i < NB - 1; i++) kr[i] <= kr[i+1];
      kr[NB-1] <= kb;
    end
  end
endmodule

// File: rtl/bsc_statepath.sv
module bsc_statepath
  import bsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ld,
  input  logic  act,
  input  logic  fin,
  input  logic  last,
  input  byte_t txt_in,
  input  byte_t kb,
  output byte_t ct_byte
);
  byte_t sr  [NB];   // substituted bytes of the running round
  byte_t yr  [NB];   // mixed bytes feeding the next round
  byte_t cur [NB];
  byte_t rot [NB];
  byte_t mix [NB];
  byte_t din, sx;

  assign din     = ld ? txt_in : yr[0];
  assign sx      = sub8(din ^ kb);
  assign ct_byte = yr[0] ^ kb;

  always_comb begin
    for (int m = 0; m < NB - 1; m++) cur[m] = sr[m+1];
    cur[NB-1] = sx;
    for (int j = 0; j < NB; j++) rot[j] = cur[(j+2) % NB];
  end

  for (genvar h = 0; h < NB / HALF; h++) begin : g_col
    for (genvar i = 0; i < HALF; i++) begin : g_row
      byte_t c0, c1, c2, c3;
      assign c0 = rot[h*HALF + i];
      assign c1 = rot[h*HALF + (i+1) % HALF];
      assign c2 = rot[h*HALF + (i+2) % HALF];
      assign c3 = rot[h*HALF + (i+3) % HALF];
      assign mix[h*HALF + i] = dbl(c0) ^ dbl(c1) ^ c1 ^ c2 ^ c3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        sr[i] <= '0;
        yr[i] <= '0;
      end
    end else begin
      if (act) begin
        for (int i = 0; i < NB - 1; i++) sr[i] <= sr[i+1];
        sr[NB-1] <= sx;
      end
      if (act && last) begin
        for (int i = 0; i < NB; i++) yr[i] <= mix[i];
      end else if (act || fin) begin
        for (int i = 0; i < NB - 1; i++) yr[i] <= yr[i+1];
        yr[NB-1] <= '0;
      end
    end
  end
endmodule

// File: rtl/bsc_encrypt.sv
module bsc_encrypt
  import bsc_pkg::*;
#(
  parameter int ROUNDS = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] txt_in,
  input  logic [7:0] key_in,
  output logic       busy,
  output logic       ct_valid,
  output logic [7:0] ct_out,
  output logic       done
);
  localparam int RW = $clog2(ROUNDS + 1);

  logic          ld, act, fin, last;
  logic [RW-1:0] rnd;
  byte_t         kb, ct_byte;

  bsc_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ld(ld), .act(act), .fin(fin),
    .last(last), .rnd(rnd), .busy(busy)
  );

  bsc_keysched #(.ROUNDS(ROUNDS)) u_key (
    .clk(clk), .rst(rst), .ld(ld), .act(act), .fin(fin), .last(last),
    .rnd(rnd), .key_in(key_in), .kb(kb)
  );

  bsc_statepath u_dp (
    .clk(clk), .rst(rst), .ld(ld), .act(act), .fin(fin), .last(last),
    .txt_in(txt_in), .kb(kb), .ct_byte(ct_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_valid <= 1'b0;
      ct_out   <= '0;
      done     <= 1'b0;
    end else begin
      ct_valid <= fin;
      ct_out   <= fin ? ct_byte : '0;
      done     <= fin && last;
    end
  end
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk #(
  parameter int ROUNDS = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       ct_valid,
  input logic [7:0] ct_out,
  input logic       done
);
  localparam int SPAN = 8 * (ROUNDS + 1) - 1;

  int unsigned vrun;
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (rst || !ct_valid) vrun <= 0;
    else                  vrun <= vrun + 1;
    if (rst || !busy) bcnt <= 0;
    else              bcnt <= bcnt + 1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> busy); // R2
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst) !ct_valid |-> ct_out == 8'h00); // R6
  AST_BURST_EIGHT: assert property (@(posedge clk) disable iff (rst) done |-> vrun == 7); // R6
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst) done |-> ct_valid); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> bcnt == SPAN); // R9
endmodule

bind bsc_encrypt bsc_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .ct_valid(ct_valid), .ct_out(ct_out), .done(done)
);

// File: tb/tb_bsc_encrypt.sv
module tb_bsc_encrypt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] txt_in = '0;
  logic [7:0] key_in = '0;
  logic       busy, ct_valid, done;
  logic [7:0] ct_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  bsc_encrypt dut (
    .clk(clk), .rst(rst), .start(start), .txt_in(txt_in), .key_in(key_in),
    .busy(busy), .ct_valid(ct_valid), .ct_out(ct_out), .done(done)
  );

  // ---- reference model written from R3..R5 ----
  function automatic logic [3:0] rs4(input logic [3:0] v);
    logic [63:0] t = 64'h7_4_A_9_1_F_B_0_C_3_2_6_8_E_D_5;
    return t[63 - 4*v -: 4];
  endfunction
  function automatic logic [7:0] rs8(input logic [7:0] b);
    return {rs4(b[7:4]), rs4(b[3:0])};
  endfunction
  function automatic logic [7:0] m2(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1B) : (b << 1);
  endfunction
  function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [63:0] key);
    logic [7:0] s [8];
    logic [7:0] k [8];
    logic [7:0] t [8];
    logic [7:0] n [8];
    logic [63:0] o;
    for (int j = 0; j < 8; j++) begin
      s[j] = pt[63-8*j -: 8];
      k[j] = key[63-8*j -: 8];
    end
    for (int r = 1; r <= 12; r++) begin
      for (int j = 0; j < 8; j++) t[(j+6) % 8] = rs8(s[j] ^ k[j]);
      for (int h = 0; h < 2; h++)
        for (int i = 0; i < 4; i++)
          s[4*h+i] = m2(t[4*h+i]) ^ m2(t[4*h+(i+1)%4]) ^ t[4*h+(i+1)%4]
                   ^ t[4*h+(i+2)%4] ^ t[4*h+(i+3)%4];
      n[0] = k[5]; n[1] = k[6]; n[2] = k[7] ^ 8'(r); n[3] = k[4];
      n[4] = k[1] ^ k[5]; n[5] = rs8(k[2] ^ k[6]); n[6] = rs8(k[3] ^ k[7]); n[7] = k[0] ^ k[4];
      for (int j = 0; j < 8; j++) k[j] = n[j];
    end
    for (int j = 0; j < 8; j++) o[63-8*j -: 8] = s[j] ^ k[j];
    return o;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one block starting at the current falling edge
  task automatic run_block(input logic [63:0] pt, input logic [63:0] key, input bit poke,
                           output logic [63:0] ct, output int first_n, output int vcnt,
                           output int done_n, output int busy_ok);
    ct = '0; first_n = -1; vcnt = 0; done_n = -1; busy_ok = 1;
    start = 1'b1; txt_in = pt[63:56]; key_in = key[63:56];
    for (int n = 1; n <= 140; n++) begin
      @(negedge clk);
      if (n < 8) begin
        start = 1'b0; txt_in = pt[63-8*n -: 8]; key_in = key[63-8*n -: 8];
      end else begin
        start  = poke && (n == 50 || n == 98);
        txt_in = poke ? 8'(n * 37) : 8'h00;
        key_in = poke ? 8'(n * 91) : 8'h00;
      end
      if (n <= 103 && !busy) busy_ok = 0;
      if (ct_valid) begin
        if (first_n < 0) first_n = n;
        if (vcnt < 8) ct[63-8*vcnt -: 8] = ct_out;
        vcnt++;
      end
      if (done) begin
        done_n = n;
        if (busy) busy_ok = 0;
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "ct_valid in reset", 64'(ct_valid), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    chk("R1", "ct_out in reset", 64'(ct_out), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {busy, ct_valid, done, ct_out}, 64'd0);
  endtask

  task automatic t_idle_quiet();
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      txt_in = 8'(i * 13 + 1); key_in = 8'(i * 7 + 3);
      @(negedge clk);
      if (busy || ct_valid || done || ct_out != 0) seen++;
    end
    txt_in = '0; key_in = '0;
    chk("R2", "idle inputs without start", 64'(seen), 64'd0);
  endtask

  task automatic t_vector(input string name, input logic [63:0] pt, input logic [63:0] key);
    logic [63:0] ct;
    int fn, vc, dn, bo;
    run_block(pt, key, 1'b0, ct, fn, vc, dn, bo);
    if (dn < 0) begin n_chk++; n_err++; $display("FAIL R8 %s watchdog: no done actual=-1 expected=104", name); end
    chk("R3", {name, " ciphertext (R4 R5)"}, ct, ref_enc(pt, key));
    chk("R7", {name, " first byte latency"}, 64'(fn), 64'd97);
    chk("R6", {name, " byte count"}, 64'(vc), 64'd8);
    chk("R8", {name, " done position"}, 64'(dn), 64'd104);
    chk("R9", {name, " busy window"}, 64'(bo), 64'd1);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] ct, pt, key;
    int fn, vc, dn, bo;
    pt = 64'h0011_2233_4455_6677; key = 64'h8899_AABB_CCDD_EEFF;
    run_block(pt, key, 1'b1, ct, fn, vc, dn, bo);
    chk("R9", "ciphertext with start poked while busy", ct, ref_enc(pt, key));
    chk("R9", "byte count with start poked", 64'(vc), 64'd8);
    repeat (12) @(negedge clk);
    chk("R9", "no second run from poked start", {busy, ct_valid}, 64'd0);
  endtask

  task automatic t_back_to_back();
    logic [63:0] c1, c2, p1, p2, k1, k2;
    int fn, vc, dn, bo;
    p1 = 64'hDEAD_BEEF_0BAD_F00D; k1 = 64'h1357_9BDF_2468_ACE0;
    p2 = 64'h8000_0000_0000_0001; k2 = 64'h0000_0000_0000_0080;
    run_block(p1, k1, 1'b0, c1, fn, vc, dn, bo);
    chk("R10", "first of pair", c1, ref_enc(p1, k1));
    run_block(p2, k2, 1'b0, c2, fn, vc, dn, bo);
    chk("R10", "second of pair", c2, ref_enc(p2, k2));
    chk("R10", "second latency", 64'(fn), 64'd97);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_idle_quiet();
    t_vector("zero", 64'h0, 64'h0);
    t_vector("ones", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    t_vector("mixed", 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    t_vector("keyonly", 64'h0, 64'h1234_5678_9ABC_DEF0);
    t_busy_ignore();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule